// File: doc/BRIEF.md
# I2C Slave Receiver with Forced Negative Acknowledge

This block is a receive-only I2C target. It watches the open-drain SCL and SDA lines through a short synchronizer running on the system clock. It finds START and STOP conditions and compares the first byte of each transfer against a 7-bit own address taken from an input port. After an acknowledged write address it shifts in data bytes and returns an acknowledge for each one. The block never drives SCL. It only pulls SDA low during an acknowledge slot.

Software reaches the block through a small register bus:

| Address | Register | Access | Contents |
|---|---|---|---|
| 0 | control | read/write | bit 0 is the force-NACK control |
| 1 | status | see requirements | event flags in bits 0 to 6 |
| 2 | data | read only | the last received byte |
| 3 | — | read only | reads as 0 |

The force-NACK control is sampled at the rising SCL edge of the eighth bit of each data byte, and that sample alone sets the acknowledge level. After a refused byte the block stays off the bus until the next START or STOP. Address acknowledges ignore the control. Five status flags are sticky and software clears them by writing 0. Two flags are kept by hardware alone.

Top module: `i2c_slave_rx`

## Requirements
- R1: After reset, the control, status and data registers read 0 and sda_pull is 0.
- R2: Address reception starts only after a START (SDA falling while SCL is high). Clocking a byte after a STOP and without a START draws no acknowledge and sets no flag. A repeated START begins a new address phase that is acknowledged like the first.
- R3: An address byte whose upper 7 bits equal own_addr and whose bit 0 is 0 is acknowledged: SDA is held low through the ninth clock. This holds whatever the force-NACK control is. It also sets status bit 0 (address hit) and status bit 5 (start match).
- R4: An address byte that matches neither own_addr nor the general-call value is not acknowledged. The data bytes that follow in that transfer are not acknowledged, do not update the data register and set no flag.
- R5: The address byte 0x00 (general call with the write bit) is acknowledged. It sets status bit 6 (general call) and status bit 5.
- R6: An address byte equal to own_addr with bit 0 set to 1 (a read) is not acknowledged. It sets status bit 2 (read request) and no other flag.
- R7: After an acknowledged address, each data byte is received MSB first. The byte is stored in the data register and status bit 1 (byte received) is set. The byte is acknowledged when control bit 0 was 0 at its eighth rising SCL edge.
- R8: When control bit 0 is 1 at the eighth rising SCL edge of a data byte, the byte is not acknowledged, although it is still stored and sets status bit 1. Status bit 3 (data refused) is set. Later bytes in the transfer are ignored until START or STOP. A change of control bit 0 after that eighth edge does not alter the acknowledge of the same byte.
- R9: A STOP sets status bit 4 (stop seen) only if an address or general call was acknowledged since the previous STOP.
- R10: Status bits 0 to 4 stay at 1 until a write to the status register carries 0 in that bit position. A 1 written to a position leaves that flag unchanged.
- R11: Writes do not affect status bits 5 and 6. Both clear on the next START or STOP.
- R12: The block has no SCL output, and sda_pull changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Sampled SCL bus line |
| sda_in | input | 1 | Sampled SDA bus line |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| own_addr | input | 7 | Own 7-bit slave address |
| reg_wr | input | 1 | Register write strobe, one clock per write |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |

## Verification
A wrong phase or bit count shows up at the ports within one byte time. The acknowledge read on SDA in the ninth clock is wrong, or the data register holds a shifted value as soon as the eighth bit has been taken. A wrong engaged or parked state appears only at a later boundary. It shows as an acknowledge on a byte that should be ignored, or as a stop-seen flag that is set or missing at the next STOP. The bench therefore reads the status register at each of these edges and does not wait for the end of the transfer. A force-NACK value captured at the wrong moment shows in the ninth clock of the same byte.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int BYTE_W = 8;
    localparam int SADDR_W = 7;
    localparam int STAT_W = 7;

    // status bit positions
    localparam int SB_ADDR_HIT = 0;
    localparam int SB_RX_BYTE  = 1;
    localparam int SB_READ_REQ = 2;
    localparam int SB_REFUSED  = 3;
    localparam int SB_STOP     = 4;
    localparam int SB_STARTM   = 5;
    localparam int SB_GCALL    = 6;
    localparam int STICKY_N    = 5;

    typedef enum logic [1:0] {
        RA_CTRL = 2'd0,
        RA_STAT = 2'd1,
        RA_DATA = 2'd2,
        RA_NONE = 2'd3
    } raddr_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_ADDR_ACK,
        PH_DATA,
        PH_DATA_ACK,
        PH_PARK
    } phase_t;

    typedef enum logic [1:0] {
        AM_NONE,
        AM_WRITE,
        AM_GCALL,
        AM_READ
    } amatch_t;

    // single-cycle events from the protocol engine to the registers
    typedef struct packed {
        logic addr_hit;
        logic gcall;
        logic read_req;
        logic rx_byte;
        logic refused;
        logic stop_seen;
        logic bus_start;
        logic bus_stop;
    } evt_t;

    function automatic amatch_t classify(input logic [BYTE_W-1:0] b,
                                         input logic [SADDR_W-1:0] own);
        if (b == '0)
            return AM_GCALL;
        else if (b[BYTE_W-1:1] == own)
            return b[0] ? AM_READ : AM_WRITE;
        else
            return AM_NONE;
    endfunction

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
    parameter int STAGES = 2,
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][W-1:0] chain;
    logic [W-1:0] prev;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain[0] <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= chain[LAST];
    end

    assign lvl  = chain[LAST];
    assign rise = chain[LAST] & ~prev;
    assign fall = ~chain[LAST] & prev;

endmodule

// File: rtl/i2cs_rx_fsm.sv
module i2cs_rx_fsm
    import i2cs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_lvl,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               sda_lvl,
    input  logic               sda_rise,
    input  logic               sda_fall,
    input  logic [SADDR_W-1:0] own_addr,
    input  logic               fnack,
    output logic               sda_pull,
    output evt_t               evt,
    output logic [BYTE_W-1:0]  rx_data
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    phase_t phase;
    logic [CNT_W-1:0] cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] nb;
    logic ack_q;
    logic cont_q;
    logic engaged;
    logic start_det;
    logic stop_det;
    amatch_t am;

    assign start_det = scl_lvl & sda_fall;
    assign stop_det  = scl_lvl & sda_rise;
    assign nb        = {shreg[BYTE_W-2:0], sda_lvl};
    assign am        = classify(nb, own_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            shreg   <= '0;
            ack_q   <= 1'b0;
            cont_q  <= 1'b0;
            engaged <= 1'b0;
            evt     <= '0;
            rx_data <= '0;
        end else begin
            evt <= '0;
            if (stop_det) begin
                evt.bus_stop  <= 1'b1;
                evt.stop_seen <= engaged;
                engaged       <= 1'b0;
                phase         <= PH_IDLE;
            end else if (start_det) begin
                evt.bus_start <= 1'b1;
                phase         <= PH_ADDR;
                cnt           <= '0;
            end else begin
                unique case (phase)
                    PH_ADDR, PH_DATA: begin
                        if (scl_rise && cnt != FULL) begin
                            shreg <= nb;
                            cnt   <= cnt + 1'b1;
                            if (cnt == LAST_BIT) begin
                                if (phase == PH_ADDR) begin
                                    unique case (am)
                                        AM_WRITE: begin
                                            ack_q <= 1'b1; cont_q <= 1'b1;
                                            engaged <= 1'b1; evt.addr_hit <= 1'b1;
                                        end
                                        AM_GCALL: begin
                                            ack_q <= 1'b1; cont_q <= 1'b1;
                                            engaged <= 1'b1; evt.gcall <= 1'b1;
                                        end
                                        AM_READ: begin
                                            ack_q <= 1'b0; cont_q <= 1'b0;
                                            evt.read_req <= 1'b1;
                                        end
                                        default: begin
                                            ack_q <= 1'b0; cont_q <= 1'b0;
                                        end
                                    endcase
                                end else begin
                                    rx_data     <= nb;
                                    evt.rx_byte <= 1'b1;
                                    evt.refused <= fnack;
                                    ack_q       <= ~fnack;
                                    cont_q      <= ~fnack;
                                end
                            end
                        end else if (scl_fall && cnt == FULL) begin
                            phase <= (phase == PH_ADDR) ? PH_ADDR_ACK : PH_DATA_ACK;
                        end
                    end
                    PH_ADDR_ACK, PH_DATA_ACK: begin
                        if (scl_fall) begin
                            phase <= cont_q ? PH_DATA : PH_PARK;
                            cnt   <= '0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_pull = ack_q & ((phase == PH_ADDR_ACK) | (phase == PH_DATA_ACK));

endmodule

// File: rtl/i2cs_regs.sv
module i2cs_regs
    import i2cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    input  evt_t              evt,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              fnack,
    output logic [STAT_W-1:0] status,
    output logic [BYTE_W-1:0] reg_rdata
);
    logic [STICKY_N-1:0] set_v;
    logic stat_wr;
    logic [BYTE_W-1:0] data_q;
    raddr_t ra;

    assign ra      = raddr_t'(reg_addr);
    assign stat_wr = reg_wr & (ra == RA_STAT);

    assign set_v[SB_ADDR_HIT] = evt.addr_hit;
    assign set_v[SB_RX_BYTE]  = evt.rx_byte;
    assign set_v[SB_READ_REQ] = evt.read_req;
    assign set_v[SB_REFUSED]  = evt.refused;
    assign set_v[SB_STOP]     = evt.stop_seen;

    // sticky flags: a hardware set wins over a clearing write in the same cycle
    for (genvar g = 0; g < STICKY_N; g++) begin : g_sticky
        always_ff @(posedge clk) begin
            if (rst)
                status[g] <= 1'b0;
            else if (set_v[g])
                status[g] <= 1'b1;
            else if (stat_wr && !reg_wdata[g])
                status[g] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            status[SB_STARTM] <= 1'b0;
        else if (evt.addr_hit || evt.gcall)
            status[SB_STARTM] <= 1'b1;
        else if (evt.bus_start || evt.bus_stop)
            status[SB_STARTM] <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            status[SB_GCALL] <= 1'b0;
        else if (evt.gcall)
            status[SB_GCALL] <= 1'b1;
        else if (evt.bus_start || evt.bus_stop)
            status[SB_GCALL] <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fnack  <= 1'b0;
            data_q <= '0;
        end else begin
            if (reg_wr && ra == RA_CTRL)
                fnack <= reg_wdata[0];
            if (evt.rx_byte)
                data_q <= rx_data;
        end
    end

    always_comb begin
        unique case (ra)
            RA_CTRL: reg_rdata = {{(BYTE_W-1){1'b0}}, fnack};
            RA_STAT: reg_rdata = {{(BYTE_W-STAT_W){1'b0}}, status};
            RA_DATA: reg_rdata = data_q;
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx
    import i2cs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_pull,
    input  logic [SADDR_W-1:0] own_addr,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [BYTE_W-1:0]  reg_wdata,
    output logic [BYTE_W-1:0]  reg_rdata
);
    logic [1:0] ln_lvl, ln_rise, ln_fall;
    logic scl_lvl;
    logic fnack;
    evt_t evt;
    logic [BYTE_W-1:0] rx_data;
    logic [STAT_W-1:0] status;

    i2cs_line_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({sda_in, scl_in}),
        .lvl  (ln_lvl),
        .rise (ln_rise),
        .fall (ln_fall)
    );

    assign scl_lvl = ln_lvl[0];

    i2cs_rx_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .scl_lvl  (scl_lvl),
        .scl_rise (ln_rise[0]),
        .scl_fall (ln_fall[0]),
        .sda_lvl  (ln_lvl[1]),
        .sda_rise (ln_rise[1]),
        .sda_fall (ln_fall[1]),
        .own_addr (own_addr),
        .fnack    (fnack),
        .sda_pull (sda_pull),
        .evt      (evt),
        .rx_data  (rx_data)
    );

    i2cs_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .evt       (evt),
        .rx_data   (rx_data),
        .fnack     (fnack),
        .status    (status),
        .reg_rdata (reg_rdata)
    );

endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker
    import i2cs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              scl_lvl,
    input logic              sda_pull,
    input logic [STAT_W-1:0] status,
    input logic              reg_wr,
    input logic [1:0]        reg_addr,
    input logic [BYTE_W-1:0] reg_wdata,
    input logic              ev_stop_seen,
    input logic              ev_rx_byte
);
    logic stat_wr;
    assign stat_wr = reg_wr && (reg_addr == 2'd1);

    a_r12_pull_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
        ($rose(sda_pull) || $fell(sda_pull)) |-> !scl_lvl);

    a_r10_rx_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (status[SB_RX_BYTE] && !(stat_wr && !reg_wdata[SB_RX_BYTE])) |=> status[SB_RX_BYTE]);

    a_r10_stop_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (status[SB_STOP] && !(stat_wr && !reg_wdata[SB_STOP])) |=> status[SB_STOP]);

    a_r11_gcall_implies_match: assert property (@(posedge clk) disable iff (rst)
        status[SB_GCALL] |-> status[SB_STARTM]);

    a_r9_stop_flag_source: assert property (@(posedge clk) disable iff (rst)
        $rose(status[SB_STOP]) |-> $past(ev_stop_seen));

    a_r7_rx_flag_source: assert property (@(posedge clk) disable iff (rst)
        $rose(status[SB_RX_BYTE]) |-> $past(ev_rx_byte));

endmodule

bind i2c_slave_rx i2cs_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .scl_lvl      (scl_lvl),
    .sda_pull     (sda_pull),
    .status       (status),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .ev_stop_seen (evt.stop_seen),
    .ev_rx_byte   (evt.rx_byte)
);

// File: tb/sim_i2c_slave_rx.sv
`timescale 1ns/1ps
module sim_i2c_slave_rx;
    localparam int Q = 8;
    localparam int H = 16;
    localparam logic [6:0] OWN = 7'h5A;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull;
    logic reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic sda_line;
    int tests = 0;
    int fails = 0;
    int viol = 0;
    bit done = 1'b0;
    logic prev_pull = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    i2c_slave_rx u0 (
        .clk       (clk),
        .rst       (rst),
        .scl_in    (scl),
        .sda_in    (sda_line),
        .sda_pull  (sda_pull),
        .own_addr  (OWN),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    // R12 monitor: the pull may only change while the bench holds SCL low
    always @(negedge clk) begin
        if (!rst && sda_pull !== prev_pull && scl) viol++;
        prev_pull <= sda_pull;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(Q);
        scl = 1'b1; wait_clk(H);
        sda_m = 1'b0; wait_clk(H);
        scl = 1'b0; wait_clk(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(Q);
        scl = 1'b1; wait_clk(H);
        sda_m = 1'b1; wait_clk(H);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit flip, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            wait_clk(Q); sda_m = b[i]; wait_clk(Q);
            scl = 1'b1;
            if (i == 0 && flip) begin
                wait_clk(Q);
                reg_write(2'd0, 8'h01);
                wait_clk(Q - 2);
            end else begin
                wait_clk(H);
            end
            scl = 1'b0;
        end
        wait_clk(Q); sda_m = 1'b1; wait_clk(Q);
        scl = 1'b1; wait_clk(Q);
        acked = !sda_line;
        wait_clk(Q);
        scl = 1'b0;
    endtask

    logic [7:0] rd;
    bit ak;

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(3);
        // R1 reset state
        reg_read(2'd0, rd); check("R1 ctrl", rd, 8'h00);
        reg_read(2'd1, rd); check("R1 status", rd, 8'h00);
        reg_read(2'd2, rd); check("R1 data", rd, 8'h00);
        check("R1 sda_pull", sda_pull, 1'b0);

        // R3 / R4 / R5 / R9 sweep over every 7-bit address with the write bit
        for (int a = 0; a < 128; a++) begin
            bit exp_ack;
            string tag;
            exp_ack = (a == OWN) || (a == 0);
            tag = (a == OWN) ? "R3" : ((a == 0) ? "R5" : "R4");
            bus_start();
            send_byte({a[6:0], 1'b0}, 1'b0, ak);
            check(tag, ak, exp_ack);
            if (exp_ack) begin
                reg_read(2'd1, rd);
                check(tag, rd, (a == 0) ? 8'h60 : 8'h21);
            end
            bus_stop();
            reg_read(2'd1, rd);
            check("R9 sweep", rd, (a == OWN) ? 8'h11 : ((a == 0) ? 8'h10 : 8'h00));
            reg_write(2'd1, 8'h00);
        end

        // R4: bytes after an unmatched address are ignored
        bus_start();
        send_byte({7'h10, 1'b0}, 1'b0, ak); check("R4 addr", ak, 1'b0);
        send_byte(8'hA5, 1'b0, ak); check("R4 data nack", ak, 1'b0);
        bus_stop();
        reg_read(2'd1, rd); check("R4 status", rd, 8'h00);
        reg_read(2'd2, rd); check("R4 data", rd, 8'h00);

        // R6: read request to own address
        bus_start();
        send_byte({OWN, 1'b1}, 1'b0, ak); check("R6 nack", ak, 1'b0);
        bus_stop();
        reg_read(2'd1, rd); check("R6 status", rd, 8'h04);
        reg_write(2'd1, 8'h00);

        // R7: data bytes acknowledged and stored
        bus_start();
        send_byte({OWN, 1'b0}, 1'b0, ak); check("R7 addr", ak, 1'b1);
        for (int k = 0; k < 64; k++) begin
            logic [7:0] d;
            d = 8'((k * 37 + 5) & 255);
            send_byte(d, 1'b0, ak); check("R7 ack", ak, 1'b1);
            reg_read(2'd2, rd); check("R7 data", rd, d);
            reg_read(2'd1, rd); check("R7 flag", rd[1], 1'b1);
            reg_write(2'd1, 8'h00);
        end
        bus_stop();
        reg_read(2'd1, rd); check("R9 after data", rd, 8'h10);
        reg_write(2'd1, 8'h00);

        // R8: forced refusal, then parked
        bus_start();
        send_byte({OWN, 1'b0}, 1'b0, ak);
        reg_write(2'd0, 8'h01);
        send_byte(8'h3C, 1'b0, ak); check("R8 nack", ak, 1'b0);
        reg_read(2'd1, rd); check("R8 status", rd, 8'h2B);
        reg_read(2'd2, rd); check("R8 data", rd, 8'h3C);
        send_byte(8'hC3, 1'b0, ak); check("R8 parked", ak, 1'b0);
        reg_read(2'd2, rd); check("R8 data kept", rd, 8'h3C);
        bus_stop();
        reg_write(2'd1, 8'h00);
        reg_write(2'd0, 8'h00);

        // R8: control changed after the eighth edge does not affect that byte
        bus_start();
        send_byte({OWN, 1'b0}, 1'b0, ak);
        send_byte(8'h77, 1'b1, ak); check("R8 late set", ak, 1'b1);
        reg_read(2'd0, rd); check("R8 ctrl", rd, 8'h01);
        send_byte(8'h88, 1'b0, ak); check("R8 next", ak, 1'b0);
        bus_stop();
        reg_write(2'd1, 8'h00);

        // R3: address acknowledged even with force-NACK set
        bus_start();
        send_byte({OWN, 1'b0}, 1'b0, ak); check("R3 fnack addr", ak, 1'b1);
        bus_stop();
        reg_write(2'd0, 8'h00);
        reg_write(2'd1, 8'h00);

        // R10 / R11: write-0-to-clear and hardware-only bits
        bus_start();
        send_byte({OWN, 1'b0}, 1'b0, ak);
        send_byte(8'h11, 1'b0, ak);
        reg_write(2'd1, 8'h7F);
        reg_read(2'd1, rd); check("R10 ones", rd, 8'h23);
        reg_write(2'd1, 8'h7D);
        reg_read(2'd1, rd); check("R10 clear one", rd, 8'h21);
        reg_write(2'd1, 8'h00);
        reg_read(2'd1, rd); check("R11 hw kept", rd, 8'h20);
        bus_stop();
        reg_read(2'd1, rd); check("R11 stop clears", rd, 8'h10);
        reg_write(2'd1, 8'h00);

        bus_start();
        send_byte(8'h00, 1'b0, ak); check("R5 gcall", ak, 1'b1);
        reg_write(2'd1, 8'h00);
        reg_read(2'd1, rd); check("R11 gcall kept", rd, 8'h60);
        bus_start();
        send_byte({7'h22, 1'b0}, 1'b0, ak);
        reg_read(2'd1, rd); check("R11 start clears", rd, 8'h00);
        bus_stop();
        reg_read(2'd1, rd); check("R9 engaged earlier", rd, 8'h10);
        reg_write(2'd1, 8'h00);

        // R2: repeated start, then a byte with no start
        bus_start();
        send_byte({OWN, 1'b0}, 1'b0, ak);
        send_byte(8'h01, 1'b0, ak);
        bus_start();
        send_byte({OWN, 1'b0}, 1'b0, ak); check("R2 restart addr", ak, 1'b1);
        send_byte(8'h02, 1'b0, ak); check("R2 restart data", ak, 1'b1);
        reg_read(2'd2, rd); check("R2 data", rd, 8'h02);
        bus_stop();
        reg_write(2'd1, 8'h00);
        send_byte({OWN, 1'b0}, 1'b0, ak); check("R2 no start", ak, 1'b0);
        reg_read(2'd1, rd); check("R2 no flags", rd, 8'h00);

        check("R12 pull timing", viol, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule